// File: doc/BRIEF.md
# Chained Write-Then-Read SPI Master

This block is a SPI master for peripherals that are addressed with a command and then answer. Each transfer shifts a programmed number of bits out and then shifts a programmed number of bits in. The write phase and the read phase each run at their own divided serial clock rate. A single recirculating shift register is used in both phases. In four-wire mode the input comes from `spi_miso`. In three-wire half-duplex mode the shared data line stops being driven once the write phase ends, and the input is taken from that line.

Software uses three 32-bit registers through a strobe/acknowledge port: data (address 0), transfer (address 1) and configuration (address 2). The data register has a one-entry holding buffer in front of the shift register. A word written while a transfer runs becomes the next transfer. That transfer is chained to the current one, so chip select is never released between them. The transfer register is sampled only when a transfer starts, so it can be rewritten safely while a transfer is in flight.

Top module: `spi_chain_master`

## Requirements
- R1: After reset, all `spi_cs_n` lines are high, `spi_sclk` is low, `spi_mosi_oe` is high, `bus_ack` is low, and reads of the data and configuration registers return zero.
- R2: A read strobe is acknowledged in the next cycle, so a read takes two cycles. The acknowledge carries the register value: transfer and configuration read back what was written, and data returns the last received word. A strobe is held until `bus_ack` is seen.
- R3: In the configuration register, bit 0 selects half-duplex, bits 23:16 hold the write divider minus two, and bits 31:24 hold the read divider minus two. A write bit lasts exactly the write divider in cycles and a read bit lasts the read divider. `spi_sclk` is low for the first ceil(div/2) cycles of each bit and high for the rest. It never pulses while no transfer runs.
- R4: In the transfer register, bits 15:0 are the chip-select mask (active-low on `spi_cs_n`), bits 23:16 are the write length and bits 31:24 are the read length. A transfer gives exactly write length plus read length rising `spi_sclk` edges. Chip select stays low for write_length·write_div + read_length·read_div cycles.
- R5: Bits go out MSB first, from bit 31 of the shift register. At the end of each bit's high half, the input bit is shifted into bit 0. When the transfer ends, the shift register content becomes readable at the data address.
- R6: With no new data loaded, bits received earlier reappear on `spi_mosi_o` after 32 bit times, because the shift register recirculates.
- R7: In half-duplex mode, `spi_mosi_oe` is low throughout the read phase and the input is taken from `spi_mosi_i`. During the write phase, the bit driven out is the bit shifted back in. In four-wire mode `spi_mosi_oe` stays high and the input comes from `spi_miso`.
- R8: A data write is acknowledged in the next cycle if the holding buffer is empty, even while a transfer runs. If the buffer is full, the write stalls until the buffer empties.
- R9: If a word is waiting when a transfer ends, the next transfer starts in the following cycle with chip select still asserted. Chip select is released only when nothing is pending.
- R10: A write to the transfer register takes effect at the start of the next transfer, including a chained one, and never alters the transfer in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, held until acknowledged |
| bus_rd | input | 1 | Read strobe, held until acknowledged |
| bus_addr | input | 2 | Register select: 0 data, 1 transfer, 2 configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle acknowledge |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Drive enable for the data-out line |
| spi_mosi_i | input | 1 | Data line readback, used in half-duplex mode |
| spi_miso | input | 1 | Serial data in, four-wire mode |
| spi_cs_n | output | CS_W | Active-low chip selects |

## Verification
A table of transfers changes one thing at a time: equal and unequal write/read dividers, including odd ones; write-only and read-only transfers; a write longer than 32 bits; and half-duplex against four-wire. Comparing the captured output stream, the received word, the clock count and the select and drive-enable durations against a bit-level model separates divider mix-ups, phase-length errors, wrong input selection and missing recirculation. A three-word chained burst follows. It rewrites the transfer register mid-flight and fills the holding buffer so that one write must stall. This distinguishes correct chaining, with a single chip-select release, from per-word release, from the new lengths being applied early, and from an overwrite of the pending word.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WRITE = 2'd1,
      PH_READ  = 2'd2
   } phase_e;

   localparam logic [1:0] REG_DATA = 2'd0;
   localparam logic [1:0] REG_XFER = 2'd1;
   localparam logic [1:0] REG_CFG  = 2'd2;

   localparam int REG_W    = 32;
   localparam int HD_BIT   = 0;
   localparam int WDIV_LSB = 16;
   localparam int RDIV_LSB = 24;
   localparam int CS_LSB   = 0;
   localparam int WLEN_LSB = 16;
   localparam int RLEN_LSB = 24;
endpackage

// File: rtl/spi_bit_timer.sv
module spi_bit_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_m2,
   output logic             sclk,
   output logic             bit_done
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] div_full, low_len, cyc;

   assign div_full = CNT_W'(div_m2) + CNT_W'(2);
   assign low_len  = div_full - (div_full >> 1);
   assign bit_done = run && (cyc == div_full - CNT_W'(1));
   assign sclk     = run && (cyc >= low_len);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || bit_done) cyc <= '0;
      else                            cyc <= cyc + CNT_W'(1);
   end

   // R3: a bit only closes in its high half
   assert_done_in_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_done |-> sclk);
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         in_bit,
   output logic [W-1:0] q,
   output logic [W-1:0] shifted
);
   assign shifted = {q[W-2:0], in_bit};

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (shift) q <= shifted;
   end
endmodule

// File: rtl/spi_bus_regs.sv
module spi_bus_regs
   import spi_chain_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CS_W   = 16,
   parameter int LEN_W  = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              bus_ack,
   input  logic              take,
   input  logic              rx_we,
   input  logic [DATA_W-1:0] rx_val,
   output logic              cfg_hd,
   output logic [DIV_W-1:0]  cfg_wdiv,
   output logic [DIV_W-1:0]  cfg_rdiv,
   output logic [CS_W-1:0]   xf_cs,
   output logic [LEN_W-1:0]  xf_wlen,
   output logic [LEN_W-1:0]  xf_rlen,
   output logic              hold_full,
   output logic [DATA_W-1:0] hold_data
);
   logic [REG_W-1:0]  cfg_q, xfer_q;
   logic [DATA_W-1:0] rx_q;
   logic              wr_go, rd_go;

   always_comb begin
      wr_go = bus_wr && !bus_ack && ((bus_addr != REG_DATA) || !hold_full);
      rd_go = bus_rd && !bus_wr && !bus_ack;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
         cfg_q     <= '0;
         xfer_q    <= '0;
         rx_q      <= '0;
         hold_full <= 1'b0;
         hold_data <= '0;
      end else begin
         bus_ack <= wr_go || rd_go;
         if (rd_go) begin
            case (bus_addr)
               REG_DATA: bus_rdata <= REG_W'(rx_q);
               REG_XFER: bus_rdata <= xfer_q;
               REG_CFG:  bus_rdata <= cfg_q;
               default:  bus_rdata <= '0;
            endcase
         end
         if (wr_go && bus_addr == REG_CFG)  cfg_q  <= bus_wdata;
         if (wr_go && bus_addr == REG_XFER) xfer_q <= bus_wdata;
         if (take) hold_full <= 1'b0;
         if (wr_go && bus_addr == REG_DATA) begin
            hold_full <= 1'b1;
            hold_data <= bus_wdata[DATA_W-1:0];
         end
         if (rx_we) rx_q <= rx_val;
      end
   end

   assign cfg_hd   = cfg_q[HD_BIT];
   assign cfg_wdiv = cfg_q[WDIV_LSB +: DIV_W];
   assign cfg_rdiv = cfg_q[RDIV_LSB +: DIV_W];
   assign xf_cs    = xfer_q[CS_LSB +: CS_W];
   assign xf_wlen  = xfer_q[WLEN_LSB +: LEN_W];
   assign xf_rlen  = xfer_q[RLEN_LSB +: LEN_W];

   // R2: a read is answered in the cycle after its strobe
   assert_read_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && !bus_ack) |=> bus_ack);
   // R8: a pending word is never dropped before the engine takes it
   assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_full && !take) |=> hold_full);
endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
   import spi_chain_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CS_W   = 16,
   parameter int LEN_W  = 8,
   parameter int DIV_W  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_wr,
   input  logic            bus_rd,
   input  logic [1:0]      bus_addr,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   output logic            bus_ack,
   output logic            spi_sclk,
   output logic            spi_mosi_o,
   output logic            spi_mosi_oe,
   input  logic            spi_mosi_i,
   input  logic            spi_miso,
   output logic [CS_W-1:0] spi_cs_n
);
   if (CS_W < 1 || CS_W > 16) begin : g_cs_w_chk
      $error("CS_W must lie in 1..16");
   end
   if (LEN_W < 1 || LEN_W > 8) begin : g_len_w_chk
      $error("LEN_W must lie in 1..8");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_div_w_chk
      $error("DIV_W must lie in 1..8");
   end
   if (DATA_W < 8 || DATA_W > REG_W) begin : g_data_w_chk
      $error("DATA_W must lie in 8..32");
   end

   logic              cfg_hd, hold_full;
   logic [DIV_W-1:0]  cfg_wdiv, cfg_rdiv, div_sel;
   logic [CS_W-1:0]   xf_cs, cs_cur;
   logic [LEN_W-1:0]  xf_wlen, xf_rlen, bits_left, rlen_cur;
   logic [DATA_W-1:0] hold_data, sr_q, sr_shifted;
   phase_e            phase;
   logic              run, bit_done, last_bit, fin, to_read, take, in_bit;

   spi_bus_regs #(.DATA_W(DATA_W), .CS_W(CS_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .take(take), .rx_we(fin), .rx_val(sr_shifted),
      .cfg_hd(cfg_hd), .cfg_wdiv(cfg_wdiv), .cfg_rdiv(cfg_rdiv),
      .xf_cs(xf_cs), .xf_wlen(xf_wlen), .xf_rlen(xf_rlen),
      .hold_full(hold_full), .hold_data(hold_data)
   );

   assign run     = (phase != PH_IDLE);
   assign div_sel = (phase == PH_READ) ? cfg_rdiv : cfg_wdiv;

   spi_bit_timer #(.DIV_W(DIV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .div_m2(div_sel),
      .sclk(spi_sclk), .bit_done(bit_done)
   );

   assign in_bit = cfg_hd ? spi_mosi_i : spi_miso;

   spi_shift_reg #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(take), .load_val(hold_data),
      .shift(bit_done), .in_bit(in_bit), .q(sr_q), .shifted(sr_shifted)
   );

   assign last_bit = bit_done && (bits_left == LEN_W'(1));
   assign fin      = last_bit && ((phase == PH_READ) || (rlen_cur == '0));
   assign to_read  = last_bit && (phase == PH_WRITE) && (rlen_cur != '0);
   assign take     = hold_full && ((phase == PH_IDLE) || fin);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         bits_left <= '0;
         rlen_cur  <= '0;
         cs_cur    <= '0;
      end else if (take) begin
         cs_cur   <= xf_cs;
         rlen_cur <= xf_rlen;
         if (xf_wlen != '0) begin
            phase     <= PH_WRITE;
            bits_left <= xf_wlen;
         end else if (xf_rlen != '0) begin
            phase     <= PH_READ;
            bits_left <= xf_rlen;
         end else begin
            phase     <= PH_IDLE;
            bits_left <= '0;
         end
      end else if (to_read) begin
         phase     <= PH_READ;
         bits_left <= rlen_cur;
      end else if (fin) begin
         phase     <= PH_IDLE;
         bits_left <= '0;
      end else if (bit_done) begin
         bits_left <= bits_left - LEN_W'(1);
      end
   end

   assign spi_mosi_o  = sr_q[DATA_W-1];
   assign spi_mosi_oe = !(cfg_hd && (phase == PH_READ));
   assign spi_cs_n    = run ? ~cs_cur : {CS_W{1'b1}};

   // R3: no serial clock while idle
   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !spi_sclk);
   // R4: a running transfer always has bits left in its phase
   assert_bits_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (bits_left != '0));
   // R9: chip select only moves when a transfer starts or the last one ends
   assert_cs_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spi_cs_n) |-> ($past(take) || $past(fin)));
endmodule

// File: tb/test_spi_chain_master.sv
`timescale 1ns/1ps
module test_spi_chain_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        bus_ack;
   logic        spi_sclk, spi_mosi_o, spi_mosi_oe, spi_mosi_i, spi_miso;
   logic [15:0] spi_cs_n;

   always #5 clk = ~clk;

   spi_chain_master i_spi_chain_master (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .spi_sclk(spi_sclk), .spi_mosi_o(spi_mosi_o),
      .spi_mosi_oe(spi_mosi_oe), .spi_mosi_i(spi_mosi_i), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n)
   );

   // slave model and line monitor
   logic [31:0] slv = 32'd0, slv_init = 32'd0;
   logic        mon_clr = 1'b1;
   logic [63:0] cap;
   int          n_rise, cs_cyc, oe_cyc, rel;
   logic [15:0] cs_last;
   logic        sclk_prev, cs_prev_low;
   wire         mosi_line = spi_mosi_oe ? spi_mosi_o : slv[31];
   assign spi_miso   = slv[31];
   assign spi_mosi_i = mosi_line;

   always @(negedge clk) begin
      if (mon_clr) begin
         cap = 64'd0; n_rise = 0; cs_cyc = 0; oe_cyc = 0; rel = 0;
         cs_last = 16'hFFFF; slv = slv_init; sclk_prev = 1'b0; cs_prev_low = 1'b0;
      end else begin
         if (spi_sclk && !sclk_prev) begin
            cap = {cap[62:0], mosi_line};
            n_rise++;
         end
         if (!spi_sclk && sclk_prev) slv = slv << 1;
         if (spi_cs_n != 16'hFFFF) begin
            cs_cyc++;
            cs_last = spi_cs_n;
         end
         if (cs_prev_low && spi_cs_n == 16'hFFFF) rel++;
         if (!spi_mosi_oe) oe_cyc++;
         sclk_prev   = spi_sclk;
         cs_prev_low = (spi_cs_n != 16'hFFFF);
      end
   end

   int total = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d, output int lat);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; lat = 0;
      do begin @(posedge clk); #1; lat++; end while (!bus_ack);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d, output int lat);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; lat = 0;
      do begin @(posedge clk); #1; lat++; end while (!bus_ack);
      d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic mon_reset(input logic [31:0] s);
      slv_init = s;
      @(posedge clk); #1 mon_clr = 1'b1;
      @(posedge clk); #1 mon_clr = 1'b0;
   endtask

   task automatic wait_done();
      wait (spi_cs_n != 16'hFFFF);
      wait (spi_cs_n == 16'hFFFF);
      @(negedge clk);
      @(negedge clk);
   endtask

   // bit-level model of one transfer built from R3..R7
   function automatic void model(input logic [31:0] data, input logic [31:0] s,
                                 input int wl, input int rl, input bit hd,
                                 output logic [31:0] rx, output logic [63:0] mcap);
      logic [31:0] sr = data;
      logic [31:0] sv = s;
      mcap = 64'd0;
      for (int k = 0; k < wl + rl; k++) begin
         logic sb, ob, ib;
         sb = sv[31];
         ob = (hd && k >= wl) ? sb : sr[31];
         ib = hd ? ((k < wl) ? sr[31] : sb) : sb;
         mcap = {mcap[62:0], ob};
         sr = {sr[30:0], ib};
         sv = sv << 1;
      end
      rx = sr;
   endfunction

   // {hd, wdiv-2, rdiv-2, wlen, rlen, data, slave pattern}
   localparam int NV = 6;
   localparam logic [103:0] VEC [NV] = '{
      {8'd0, 8'd0, 8'd0, 8'd8,  8'd8,  32'hA5C30F1E, 32'h3C96E10B},
      {8'd0, 8'd3, 8'd1, 8'd12, 8'd4,  32'h5A17C3E9, 32'h9E3779B9},
      {8'd1, 8'd2, 8'd0, 8'd8,  8'd8,  32'hC0FFEE11, 32'h8BADF00D},
      {8'd0, 8'd0, 8'd5, 8'd0,  8'd16, 32'h12345678, 32'hF0E1D2C3},
      {8'd0, 8'd1, 8'd0, 8'd40, 8'd0,  32'hDEADBEEF, 32'h6A09E667},
      {8'd1, 8'd0, 8'd2, 8'd16, 8'd16, 32'h0F0F55AA, 32'hB7E15162}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin : main
      logic [31:0] rd, rxe;
      logic [63:0] cape;
      int lat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(spi_cs_n == 16'hFFFF, "R1 cs_n", 64'(spi_cs_n), 64'hFFFF);
      chk(!spi_sclk && spi_mosi_oe && !bus_ack, "R1 sclk/oe/ack",
          {spi_sclk, spi_mosi_oe, bus_ack}, 3'b010);
      bus_read(2'd0, rd, lat);
      chk(rd == 32'd0, "R1 data", rd, 0);
      chk(lat == 1, "R2 read latency", lat, 1);
      bus_read(2'd2, rd, lat);
      chk(rd == 32'd0, "R1 config", rd, 0);
      // R2 readback
      bus_write(2'd2, 32'h0701_0001, lat);
      bus_read(2'd2, rd, lat);
      chk(rd == 32'h0701_0001 && lat == 1, "R2 config readback", rd, 32'h0701_0001);
      bus_write(2'd1, 32'h1020_00A5, lat);
      bus_read(2'd1, rd, lat);
      chk(rd == 32'h1020_00A5 && lat == 1, "R2 transfer readback", rd, 32'h1020_00A5);

      // table of transfers
      for (int v = 0; v < NV; v++) begin
         logic [103:0] e;
         int wl, rl, wd, rdv, hd;
         e  = VEC[v];
         hd = int'(e[96]); wd = int'(e[95:88]) + 2; rdv = int'(e[87:80]) + 2;
         wl = int'(e[79:72]); rl = int'(e[71:64]);
         bus_write(2'd2, {e[87:80], e[95:88], 15'd0, e[96]}, lat);
         bus_write(2'd1, {e[71:64], e[79:72], 16'h0005}, lat);
         mon_reset(e[31:0]);
         bus_write(2'd0, e[63:32], lat);
         wait_done();
         model(e[63:32], e[31:0], wl, rl, hd[0], rxe, cape);
         bus_read(2'd0, rd, lat);
         chk(rd == rxe, (hd != 0) ? "R7 received word" : "R5 received word", rd, rxe);
         chk(cap == cape, (wl > 32) ? "R6 recirculated output" : "R5 output stream", cap, cape);
         chk(n_rise == wl + rl, "R4 clock count", n_rise, wl + rl);
         chk(cs_cyc == wl * wd + rl * rdv, "R3 select duration", cs_cyc, wl * wd + rl * rdv);
         chk(oe_cyc == ((hd != 0) ? rl * rdv : 0), "R7 drive release", oe_cyc,
             (hd != 0) ? rl * rdv : 0);
         chk(cs_last == ~16'h0005 && rel == 1, "R4 select mask", cs_last, ~16'h0005);
      end

      // chained burst: R8 R9 R10
      begin
         logic [31:0] ra, rb, rc;
         logic [63:0] ca, cb, cc;
         int la, lb, lc;
         bus_write(2'd2, 32'h0000_0000, lat);
         bus_write(2'd1, {8'd0, 8'd8, 16'h0005}, lat);
         mon_reset(32'hC3A5_5A3C);
         bus_write(2'd0, 32'h8137_E6F0, la);
         wait (spi_cs_n != 16'hFFFF);
         bus_write(2'd1, {8'd4, 8'd4, 16'h0005}, lat);
         bus_write(2'd0, 32'h4E92_1BD7, lb);
         bus_write(2'd0, 32'hB5F0_2C69, lc);
         wait_done();
         model(32'h8137_E6F0, 32'hC3A5_5A3C,       8, 0, 1'b0, ra, ca);
         model(32'h4E92_1BD7, 32'hC3A5_5A3C << 8,  4, 4, 1'b0, rb, cb);
         model(32'hB5F0_2C69, 32'hC3A5_5A3C << 16, 4, 4, 1'b0, rc, cc);
         chk(la == 1, "R8 idle write ack", la, 1);
         chk(lb == 1, "R8 buffered write ack", lb, 1);
         chk(lc > 1, "R8 stall on full buffer", lc, 2);
         chk(n_rise == 24, "R10 new lengths on chained start", n_rise, 24);
         chk(rel == 1, "R9 single select release", rel, 1);
         chk(cs_cyc == 48, "R9 select held across chain", cs_cyc, 48);
         chk(cap == {40'd0, ca[7:0], cb[7:0], cc[7:0]}, "R5 chained output stream", cap,
             {40'd0, ca[7:0], cb[7:0], cc[7:0]});
         bus_read(2'd0, rd, lat);
         chk(rd == rc, "R9 last chained word", rd, rc);
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule